// File: doc/BRIEF.md
# Destination Address Match CAM

This block decides, in real time, whether the destination address of a received frame is one the station wants. Address bytes arrive one per cycle from the receive path and are placed into a six-byte compare key. When the last byte is in, the key is compared against up to 64 stored 48-bit entries in parallel. A match or no-match result is then presented with a fixed latency, so the frame logic can sample it in a known cycle.

A host maintains the table without addressing the array directly. It works through three 16-bit data words that together hold one 48-bit address and a 16-bit command word. The command word names an entry and an operation: read, write or compare. Only one operation can use the single-port array in any cycle. A network compare is never held back. A host operation waits for a cycle in which no network compare takes place. Entries can be added or removed while frames are flowing.

Top module: `addr_cam`

## Requirements
- R1: After reset, `match_valid` and `match_hit` are 0, the three data words read 0, the command word reads 0x8000 (done bit set), and no entry can match.
- R2: A byte with `rx_sof`=1 is the first address byte. It fills key bits [47:40], and the next five accepted bytes fill [39:32], [31:24], [23:16], [15:8] and [7:0]. Bytes arriving before any start, or after the sixth byte, are ignored. A new start discards a partial key.
- R3: `match_valid` is high for exactly one cycle. It rises on the clock edge right after the edge that captures the sixth address byte.
- R4: `match_hit` is 1 in that cycle exactly when some valid entry equals the assembled key, and it is 0 whenever `match_valid` is 0.
- R5: Only entries with their valid bit set take part in compares. Writing an entry with the valid bit cleared removes it.
- R6: Host address 0, 1 and 2 select data bits [15:0], [31:16] and [47:32], and address 3 selects the command word. The command fields are: bit 15 done, bit 12 valid, bits 9:8 operation (0 read, 1 write, 2 compare, 3 no-op) and bits 5:0 entry index. Writing the command with bit 15 = 0 starts the operation, and bit 15 reads 0 until it completes.
- R7: A read copies the entry's address into the data words and its valid bit into command bit 12.
- R8: A host compare uses the data words as key. It writes data word 0 as {hit at bit 15, lowest matching index at bits 5:0}, which is 0x0000 on a miss, and leaves data words 1 and 2 unchanged.
- R9: A host operation completes on the edge after the command write when no network compare is under way. If a network compare occupies that cycle, the host operation is delayed by one cycle, and the network result is never delayed.
- R10: While an operation is pending, host writes to any register are ignored.
- R11: An entry written between two compares, even while a frame's address bytes are arriving, takes part in the next network compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_sof | input | 1 | Marks the first destination address byte |
| rx_data | input | 8 | Receive byte |
| match_valid | output | 1 | One-cycle result strobe |
| match_hit | output | 1 | Address found among valid entries |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |

## Verification
The network side is driven with several patterns. Keys that equal a stored entry are set against keys that differ from it only in the last byte. The byte order of a matching key is reversed, to show where each byte lands in the key. Stray bytes and a restarted partial key check that the count of address bytes is kept. Entries are added and then removed while traffic is running, and the same key must switch between hit and miss. A host compare is started on the same edge as a sixth network byte. That collision shows that the host waits one cycle and the network result does not.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

    localparam int HWORD_W = 16;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CMP   = 2'd2,
        OP_NOP   = 2'd3
    } cam_op_e;

    // Command word: done, valid, operation and entry index; other bits read 0
    typedef struct packed {
        logic       done;
        logic [1:0] rsv_hi;
        logic       valid;
        logic [1:0] rsv_mid;
        cam_op_e    op;
        logic [1:0] rsv_lo;
        logic [5:0] index;
    } cam_cmd_t;

    localparam logic [HWORD_W-1:0] CMD_MASK  = 16'h933F;
    localparam logic [HWORD_W-1:0] CMD_RESET = 16'h8000;

    function automatic logic [HWORD_W-1:0] hit_word(input logic hit, input logic [5:0] idx);
        return {hit, 9'b0, idx};
    endfunction

endpackage

// File: rtl/cam_rx_assembler.sv
module cam_rx_assembler #(
    parameter int BYTES  = 6,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_valid,
    input  logic                     rx_sof,
    input  logic [BYTE_W-1:0]        rx_data,
    output logic [BYTES*BYTE_W-1:0]  key_o,
    output logic                     fire_o
);
    localparam int CNT_W = $clog2(BYTES + 1);

    logic [CNT_W-1:0]              cnt;
    logic [BYTES-1:0][BYTE_W-1:0]  slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= CNT_W'(BYTES);
            slots  <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    slots[BYTES-1] <= rx_data;
                    cnt            <= CNT_W'(1);
                end else if (cnt < CNT_W'(BYTES)) begin
                    slots[BYTES-1-int'(cnt)] <= rx_data;
                    cnt                      <= cnt + 1'b1;
                    if (cnt == CNT_W'(BYTES-1))
                        fire_o <= 1'b1;
                end
            end
        end
    end

    assign key_o = slots;

endmodule

// File: rtl/cam_array.sv
module cam_array #(
    parameter int ENTRIES = 64,
    parameter int KEY_W   = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [KEY_W-1:0]  rd_key,
    output logic              rd_valid,
    input  logic [KEY_W-1:0]  cmp_key,
    output logic              cmp_hit,
    output logic [IDX_W-1:0]  cmp_idx
);
    logic [KEY_W-1:0]   keys [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] line_hit;

    always_ff @(posedge clk) begin
        if (wr_en)
            keys[wr_idx] <= wr_key;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vld <= '0;
        else if (wr_en)
            vld[wr_idx] <= wr_valid;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_line
        assign line_hit[g] = vld[g] && (keys[g] == cmp_key);
    end

    always_comb begin
        cmp_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (line_hit[i])
                cmp_idx = IDX_W'(i);
        end
    end

    assign cmp_hit  = |line_hit;
    assign rd_key   = keys[rd_idx];
    assign rd_valid = vld[rd_idx];

endmodule

// File: rtl/cam_host_if.sv
module cam_host_if
    import addr_cam_pkg::*;
#(
    parameter int KEY_W = 48,
    parameter int IDX_W = 6,
    parameter int AW    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [AW-1:0]       host_addr,
    input  logic [HWORD_W-1:0]  host_wdata,
    output logic [HWORD_W-1:0]  host_rdata,
    input  logic                grant_i,
    output logic                busy_o,
    output logic                done_o,
    output cam_op_e             op_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                wvalid_o,
    output logic [KEY_W-1:0]    key_o,
    input  logic [KEY_W-1:0]    rd_key_i,
    input  logic                rd_valid_i,
    input  logic                hit_i,
    input  logic [IDX_W-1:0]    hit_idx_i
);
    localparam int DWORDS = KEY_W / HWORD_W;

    logic [DWORDS-1:0][HWORD_W-1:0] dregs;
    cam_cmd_t                       cmd;
    logic                           pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            dregs   <= '0;
            cmd     <= cam_cmd_t'(CMD_RESET);
            pending <= 1'b0;
        end else if (pending) begin
            if (grant_i) begin
                unique case (cmd.op)
                    OP_READ: begin
                        dregs     <= rd_key_i;
                        cmd.valid <= rd_valid_i;
                    end
                    OP_CMP:   dregs[0] <= hit_word(hit_i, 6'(hit_idx_i));
                    default: ;
                endcase
                cmd.done <= 1'b1;
                pending  <= 1'b0;
            end
        end else if (host_wr) begin
            if (int'(host_addr) < DWORDS) begin
                dregs[host_addr] <= host_wdata;
            end else if (int'(host_addr) == DWORDS) begin
                cmd     <= cam_cmd_t'(host_wdata & CMD_MASK);
                pending <= ~host_wdata[HWORD_W-1];
            end
        end
    end

    always_comb begin
        if (int'(host_addr) < DWORDS)
            host_rdata = dregs[host_addr];
        else if (int'(host_addr) == DWORDS)
            host_rdata = cmd;
        else
            host_rdata = '0;
    end

    assign busy_o   = pending;
    assign done_o   = cmd.done;
    assign op_o     = cmd.op;
    assign idx_o    = cmd.index[IDX_W-1:0];
    assign wvalid_o = cmd.valid;
    assign key_o    = dregs;

endmodule

// File: rtl/addr_cam.sv
module addr_cam
    import addr_cam_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int BYTES   = 6,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic [BYTE_W-1:0]   rx_data,
    output logic                match_valid,
    output logic                match_hit,
    input  logic                host_wr,
    input  logic [1:0]          host_addr,
    input  logic [HWORD_W-1:0]  host_wdata,
    output logic [HWORD_W-1:0]  host_rdata
);
    localparam int KEY_W = BYTES * BYTE_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [KEY_W-1:0] rx_key, host_key, cmp_key, rd_key;
    logic             net_cmp, host_busy, host_grant, host_done;
    logic             arr_wr, rd_valid, cmp_hit, wvalid;
    logic [IDX_W-1:0] host_idx, cmp_idx;
    cam_op_e          host_op;

    cam_rx_assembler #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_asm (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .key_o(rx_key), .fire_o(net_cmp)
    );

    cam_host_if #(.KEY_W(KEY_W), .IDX_W(IDX_W), .AW(2)) u_host (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .grant_i(host_grant), .busy_o(host_busy), .done_o(host_done),
        .op_o(host_op), .idx_o(host_idx), .wvalid_o(wvalid), .key_o(host_key),
        .rd_key_i(rd_key), .rd_valid_i(rd_valid),
        .hit_i(cmp_hit), .hit_idx_i(cmp_idx)
    );

    // The network compare owns the array in its cycle; the host takes any other
    assign host_grant = host_busy && !net_cmp;
    assign arr_wr     = host_grant && (host_op == OP_WRITE);
    assign cmp_key    = net_cmp ? rx_key : host_key;

    cam_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(arr_wr), .wr_idx(host_idx), .wr_key(host_key), .wr_valid(wvalid),
        .rd_idx(host_idx), .rd_key(rd_key), .rd_valid(rd_valid),
        .cmp_key(cmp_key), .cmp_hit(cmp_hit), .cmp_idx(cmp_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
        end else begin
            match_valid <= net_cmp;
            match_hit   <= net_cmp && cmp_hit;
        end
    end

endmodule

// File: rtl/addr_cam_chk.sv
module addr_cam_chk (
    input logic clk,
    input logic rst,
    input logic net_cmp,
    input logic host_grant,
    input logic host_done,
    input logic match_valid,
    input logic match_hit
);
    // R3: a network compare yields its result on the next edge
    assert_result_latency_R3: assert property (@(posedge clk) disable iff (rst)
        net_cmp |=> match_valid);

    // R3: the result strobe lasts a single cycle
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);

    // R4: no hit without a strobe
    assert_hit_qualified_R4: assert property (@(posedge clk) disable iff (rst)
        !match_valid |-> !match_hit);

    // R9: the host never uses the array in a network compare cycle
    assert_no_shared_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        !(net_cmp && host_grant));

    // R9: a granted host operation reports done on the next edge
    assert_grant_done_R9: assert property (@(posedge clk) disable iff (rst)
        host_grant |=> host_done);
endmodule

bind addr_cam addr_cam_chk i_addr_cam_chk (
    .clk(clk), .rst(rst), .net_cmp(net_cmp), .host_grant(host_grant),
    .host_done(host_done), .match_valid(match_valid), .match_hit(match_hit)
);

// File: tb/test_addr_cam.sv
module test_addr_cam;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        match_valid, match_hit;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd3;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int checks = 0, errors = 0, cyc = 0;
    int exp_cyc_q[$];
    bit exp_hit_q[$];
    logic [47:0] ref_key [64];
    bit          ref_val [64];

    localparam logic [47:0] KA = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] KB = 48'h0A1B2C3D4E60;
    localparam logic [47:0] KC = 48'h112233445566;

    always #2 clk = ~clk;   // 250 MHz

    addr_cam i_addr_cam (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .match_valid(match_valid), .match_hit(match_hit),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic bit model_hit(input logic [47:0] k);
        for (int i = 0; i < 64; i++)
            if (ref_val[i] && ref_key[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    // Reference model of the result strobe, compared on every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_cyc_q.size() > 0 && exp_cyc_q[0] == cyc) begin
                check(match_valid === 1'b1 && match_hit === exp_hit_q[0], "R3/R4 result",
                      {62'b0, match_valid, match_hit}, {62'b0, 1'b1, exp_hit_q[0]});
                void'(exp_cyc_q.pop_front());
                void'(exp_hit_q.pop_front());
            end else begin
                check(match_valid === 1'b0 && match_hit === 1'b0, "R3 idle strobe",
                      {62'b0, match_valid, match_hit}, 64'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic net_bytes(input logic [47:0] k, input int from, input int upto);
        for (int b = from; b <= upto; b++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (b == 0);
            rx_data  = k[47-8*b -: 8];
            if (b == 5) begin
                exp_cyc_q.push_back(cyc + 2);
                exp_hit_q.push_back(model_hit(k));
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic stray_byte(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b0; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    function automatic logic [15:0] mk_cmd(input logic [1:0] op, input bit v, input int idx);
        return {1'b0, 2'b0, v, 2'b0, op, 2'b0, 6'(idx)};
    endfunction

    task automatic set_key(input logic [47:0] k);
        reg_wr(2'd0, k[15:0]);
        reg_wr(2'd1, k[31:16]);
        reg_wr(2'd2, k[47:32]);
    endtask

    // Launch a command and count cycles until done reads back as 1
    task automatic host_op(input logic [1:0] op, input bit v, input int idx, output int lat);
        logic [15:0] r;
        reg_wr(2'd3, mk_cmd(op, v, idx));
        lat = 0;
        reg_rd(2'd3, r);
        while (r[15] == 1'b0 && lat < 20) begin
            @(negedge clk);
            lat++;
            reg_rd(2'd3, r);
        end
    endtask

    task automatic write_entry(input int idx, input logic [47:0] k, input bit v);
        int lat;
        set_key(k);
        host_op(2'd1, v, idx, lat);
        check(lat == 1, "R9 write latency", 64'(lat), 64'd1);
        ref_key[idx] = k;
        ref_val[idx] = v;
    endtask

    initial begin
        logic [15:0] r;
        int lat;
        for (int i = 0; i < 64; i++) begin ref_key[i] = '0; ref_val[i] = 1'b0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        reg_rd(2'd3, r); check(r == 16'h8000, "R1 command reset", 64'(r), 64'h8000);
        for (int a = 0; a < 3; a++) begin
            reg_rd(2'(a), r); check(r == 16'h0, "R1 data reset", 64'(r), 64'h0);
        end
        net_bytes(KA, 0, 5);          // R1: empty table misses

        // R6/R4: add entry 5 and look it up from the network
        write_entry(5, KA, 1'b1);
        net_bytes(KA, 0, 5);
        net_bytes(KB, 0, 5);          // last byte differs: miss

        // R2: byte order matters
        net_bytes({KA[7:0], KA[15:8], KA[23:16], KA[31:24], KA[39:32], KA[47:40]}, 0, 5);
        // R2: stray bytes before a start and after the sixth byte are ignored
        stray_byte(8'h0A); stray_byte(8'h1B);
        net_bytes(KA, 0, 5);
        stray_byte(8'h77); stray_byte(8'h88); stray_byte(8'h99);
        // R2: a new start discards a partial key
        net_bytes(KC, 0, 2);
        net_bytes(KA, 0, 5);

        // R7: read back entries
        set_key(48'h0);
        host_op(2'd0, 1'b0, 5, lat);
        check(lat == 1, "R9 read latency", 64'(lat), 64'd1);
        reg_rd(2'd0, r); check(r == KA[15:0],  "R7 read word0", 64'(r), 64'(KA[15:0]));
        reg_rd(2'd1, r); check(r == KA[31:16], "R7 read word1", 64'(r), 64'(KA[31:16]));
        reg_rd(2'd2, r); check(r == KA[47:32], "R7 read word2", 64'(r), 64'(KA[47:32]));
        reg_rd(2'd3, r); check(r[12] == 1'b1, "R7 read valid", 64'(r[12]), 64'd1);
        host_op(2'd0, 1'b0, 7, lat);
        reg_rd(2'd3, r); check(r[12] == 1'b0, "R7 empty valid", 64'(r[12]), 64'd0);

        // R8: host compare, lowest index wins
        write_entry(40, KA, 1'b1);
        set_key(KA);
        host_op(2'd2, 1'b0, 0, lat);
        reg_rd(2'd0, r); check(r == 16'h8005, "R8 compare hit", 64'(r), 64'h8005);
        set_key(KC);
        host_op(2'd2, 1'b0, 0, lat);
        reg_rd(2'd0, r); check(r == 16'h0000, "R8 compare miss", 64'(r), 64'h0);
        reg_rd(2'd1, r); check(r == KC[31:16], "R8 word1 kept", 64'(r), 64'(KC[31:16]));
        reg_rd(2'd2, r); check(r == KC[47:32], "R8 word2 kept", 64'(r), 64'(KC[47:32]));

        // R6: no-op completes and changes nothing
        host_op(2'd3, 1'b0, 5, lat);
        check(lat == 1, "R6 no-op done", 64'(lat), 64'd1);

        // R5: removal by clearing the valid bit
        write_entry(5, KA, 1'b0);
        net_bytes(KA, 0, 5);          // entry 40 still hits
        write_entry(40, KA, 1'b0);
        net_bytes(KA, 0, 5);          // now a miss
        set_key(KA);
        host_op(2'd2, 1'b0, 0, lat);
        reg_rd(2'd0, r); check(r == 16'h0000, "R5 removed entry", 64'(r), 64'h0);

        // R11: add an entry while a key is partly assembled
        net_bytes(KC, 0, 2);
        write_entry(9, KC, 1'b1);
        net_bytes(KC, 3, 5);

        // R9/R10: host compare launched on the edge that takes the sixth byte
        write_entry(12, KB, 1'b1);
        set_key(KB);
        for (int b = 0; b < 6; b++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (b == 0); rx_data = KB[47-8*b -: 8];
            if (b == 5) begin
                exp_cyc_q.push_back(cyc + 2);
                exp_hit_q.push_back(model_hit(KB));
                host_wr = 1'b1; host_addr = 2'd3; host_wdata = mk_cmd(2'd2, 1'b0, 0);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        host_addr = 2'd1; host_wdata = 16'hDEAD;   // lands while pending
        @(negedge clk);
        host_wr = 1'b0;
        reg_rd(2'd3, r); check(r[15] == 1'b0, "R9 host waits", 64'(r[15]), 64'd0);
        @(negedge clk);
        reg_rd(2'd3, r); check(r[15] == 1'b1, "R9 host done", 64'(r[15]), 64'd1);
        reg_rd(2'd1, r); check(r == KB[31:16], "R10 write ignored", 64'(r), 64'(KB[31:16]));
        reg_rd(2'd0, r); check(r == 16'h800C, "R8 compare after wait", 64'(r), 64'h800C);

        repeat (4) @(negedge clk);
        check(exp_cyc_q.size() == 0, "R3 all results seen", 64'(exp_cyc_q.size()), 64'd0);
        finish_run();
    end
endmodule